// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable model of a single-port synchronous SRAM with a registered address stage, a one-stage read pipeline and a short-burst address generator. A cycle opens when either of two address-strobe inputs is taken while the part is selected. The strobe meant for a processor is honoured only while the primary enable is active. The strobe meant for a memory controller is always sampled. After a cycle opens, the advance input steps the two low address bits for the next beats. While advance is inactive, the same word is accessed again.

Writes are plain byte-masked stores. They use a global-write input or a byte-write enable combined with one select per 8-bit lane. The tri-state output is modelled as a data bus plus a valid flag. The flag falls one edge after a deselect cycle is registered. It also falls whenever output enable is inactive at the edge that moves the data out. The full part uses `ADDR_W = 15` (32K words of 32 bits). The default configuration is smaller so that elaboration stays light.

Top module: `burst_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits. A word stored at an address is returned unchanged by a later read of that address.
- R2: An address taken at edge N by an accepted strobe drives `rdata` with that word, and raises `rvalid`, after edge N+1.
- R3: Each access cycle with `adv_n` low and no strobe moves the address to the next burst address. Only bits [1:0] advance, in linear order modulo 4, so the fifth access returns to the base. The upper bits never change within a burst.
- R4: A cycle with `adv_n` high and no strobe keeps the burst address. The same word is read again.
- R5: A strobe accepted partway through a burst loads the new base address. The burst continues from that base.
- R6: The part is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. An accepted strobe while unselected is a deselect cycle. `rvalid` is 0 after the next edge, and no later cycle accesses the array until a new strobe is accepted.
- R7: `strobe_cpu_n` low while `sel_a_n` is high is ignored. The cycle behaves as if no strobe were present.
- R8: A cycle opened by `strobe_cpu_n` is always a read, whatever the write inputs are. The processor strobe takes priority when both strobes are low.
- R9: A write happens in an access cycle when `wr_all_n`=0, which writes all lanes. It also happens when `wr_byte_n`=0, which writes each lane i whose `lane_wr_n[i]`=0; lane i is bits [8i+7:8i]. Lanes that are not written keep their contents. An access cycle that writes nothing is a read.
- R10: `oe_n` is sampled at the edge that moves the data out. When it is high at that edge, `rvalid` is 0 for that beat.
- R11: While `rst_n` is low, and after it is released, `rvalid` is 0 and no burst is active until a strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control and output state |
| addr | input | ADDR_W | Word address |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Primary chip enable, active low |
| sel_b_n | input | 1 | Second chip enable, active low |
| sel_c | input | 1 | Third chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | DATA_W/8 | Per-lane write selects, active low |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, meaningful while rvalid is 1 |
| rvalid | output | 1 | Output driven (0 models high impedance) |

## Verification
The hardest state to reach is a burst that is already running when something interrupts it. The interruption may be a fresh strobe, an ignored processor strobe, a deselect or a paused advance. Each of these must land on a beat whose read is still in the pipeline. The bench first fills a 64-word array with values that are a function of the address. It then runs every base address through a five-beat burst and injects each interruption on a chosen beat. A cycle-level reference, written from the requirements, predicts every output beat, including the word still in flight when a deselect arrives.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_START = 2'd1,
      CYC_CONT  = 2'd2,
      CYC_DESEL = 2'd3
   } cyc_kind_e;

   localparam int LANE_BITS = 8;
endpackage

// File: rtl/burst_sram_decode.sv
module burst_sram_decode
   import burst_sram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             strobe_cpu_n,
   input  logic             strobe_ctl_n,
   input  logic             sel_a_n,
   input  logic             sel_b_n,
   input  logic             sel_c,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_wr_n,
   input  logic             active,
   output cyc_kind_e        kind,
   output logic [LANES-1:0] wmask
);
   logic selected;
   logic cpu_taken;
   logic start;
   logic [LANES-1:0] raw_mask;

   assign selected  = !sel_a_n && !sel_b_n && sel_c;
   assign cpu_taken = !strobe_cpu_n && !sel_a_n;
   assign start     = cpu_taken || !strobe_ctl_n;

   always_comb begin
      if (start)       kind = selected ? CYC_START : CYC_DESEL;
      else if (active) kind = CYC_CONT;
      else             kind = CYC_IDLE;
   end

   always_comb begin
      if (!wr_all_n)      raw_mask = '1;
      else if (!wr_byte_n) raw_mask = ~lane_wr_n;
      else                raw_mask = '0;
   end

   always_comb begin
      wmask = '0;
      if (kind == CYC_CONT)                    wmask = raw_mask;
      else if (kind == CYC_START && !cpu_taken) wmask = raw_mask;
   end
endmodule

// File: rtl/burst_sram_addr.sv
module burst_sram_addr
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W  = 11,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_kind_e         kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic              adv_n,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              active
);
   localparam int HI_W = ADDR_W - BURST_W;

   logic [BURST_W-1:0] next_lo;
   assign next_lo = cur_addr[BURST_W-1:0] + BURST_W'(1);

   always_comb begin
      case (kind)
         CYC_START: eff_addr = addr;
         CYC_CONT:  eff_addr = adv_n ? cur_addr
                                     : {cur_addr[ADDR_W-1 -: HI_W], next_lo};
         default:   eff_addr = cur_addr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cur_addr <= '0;
      end else begin
         case (kind)
            CYC_START: begin
               active   <= 1'b1;
               cur_addr <= eff_addr;
            end
            CYC_CONT:  cur_addr <= eff_addr;
            CYC_DESEL: active   <= 1'b0;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
   parameter int ADDR_W = 11,
   parameter int LANES  = 4
) (
   input  logic                 clk,
   input  logic [LANES-1:0]     we,
   input  logic [ADDR_W-1:0]    waddr,
   input  logic [8*LANES-1:0]   wdata,
   input  logic                 re,
   input  logic [ADDR_W-1:0]    raddr,
   output logic [8*LANES-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] mem [DEPTH];
      logic [7:0] rd_q;
      always_ff @(posedge clk) begin
         if (we[g]) mem[waddr] <= wdata[8*g +: 8];
         if (re)    rd_q       <= mem[raddr];
      end
      assign rdata[8*g +: 8] = rd_q;
   end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W  = 11,
   parameter int DATA_W  = 32,
   parameter int BURST_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       strobe_cpu_n,
   input  logic                       strobe_ctl_n,
   input  logic                       adv_n,
   input  logic                       sel_a_n,
   input  logic                       sel_b_n,
   input  logic                       sel_c,
   input  logic                       oe_n,
   input  logic                       wr_all_n,
   input  logic                       wr_byte_n,
   input  logic [DATA_W/8-1:0]        lane_wr_n,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic                       rvalid
);
   localparam int LANES = DATA_W / LANE_BITS;

   if (DATA_W % LANE_BITS != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
      $error("BURST_W must lie between 1 and ADDR_W-1");
   end

   cyc_kind_e         kind;
   logic [LANES-1:0]  wmask;
   logic [ADDR_W-1:0] eff_addr;
   logic [ADDR_W-1:0] cur_addr;
   logic              active;
   logic              acc_read;
   logic              rd_pend;
   logic [ADDR_W-1:0] rd_addr;

   burst_sram_decode #(.LANES(LANES)) u_dec (
      .strobe_cpu_n (strobe_cpu_n),
      .strobe_ctl_n (strobe_ctl_n),
      .sel_a_n      (sel_a_n),
      .sel_b_n      (sel_b_n),
      .sel_c        (sel_c),
      .wr_all_n     (wr_all_n),
      .wr_byte_n    (wr_byte_n),
      .lane_wr_n    (lane_wr_n),
      .active       (active),
      .kind         (kind),
      .wmask        (wmask)
   );

   burst_sram_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_adr (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .addr     (addr),
      .adv_n    (adv_n),
      .eff_addr (eff_addr),
      .cur_addr (cur_addr),
      .active   (active)
   );

   assign acc_read = (kind == CYC_START || kind == CYC_CONT) && (wmask == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         rd_addr <= '0;
         rvalid  <= 1'b0;
      end else begin
         rd_pend <= acc_read;
         rd_addr <= eff_addr;
         rvalid  <= rd_pend && !oe_n;
      end
   end

   burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_arr (
      .clk   (clk),
      .we    (wmask),
      .waddr (eff_addr),
      .wdata (wdata),
      .re    (rd_pend),
      .raddr (rd_addr),
      .rdata (rdata)
   );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
   parameter int ADDR_W  = 11,
   parameter int BURST_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              strobe_cpu_n,
   input logic              strobe_ctl_n,
   input logic              adv_n,
   input logic              sel_a_n,
   input logic              sel_b_n,
   input logic              sel_c,
   input logic              oe_n,
   input logic              rvalid,
   input logic              active,
   input logic              rd_pend,
   input logic [ADDR_W-1:0] cur_addr
);
   logic sel_ok;
   logic taken;
   assign sel_ok = !sel_a_n && !sel_b_n && sel_c;
   assign taken  = (!strobe_cpu_n && !sel_a_n) || !strobe_ctl_n;

   p_rd_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pend && !oe_n) |=> rvalid);

   p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |=> !rvalid);

   p_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !sel_ok) |=> (!active ##1 !rvalid));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && adv_n && !taken) |=> (active && $stable(cur_addr)));

   p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !taken) |=> cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W]));

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !adv_n && !taken) |=>
         cur_addr[BURST_W-1:0] == BURST_W'($past(cur_addr[BURST_W-1:0]) + 1'b1));

   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && sel_ok) |=> (active && cur_addr == $past(addr)));

   p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_cpu_n && sel_a_n && strobe_ctl_n && !active) |=> !active);

   p_reset_r11: assert property (@(posedge clk)
      !rst_n |=> (!rvalid && !active));
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr         (addr),
   .strobe_cpu_n (strobe_cpu_n),
   .strobe_ctl_n (strobe_ctl_n),
   .adv_n        (adv_n),
   .sel_a_n      (sel_a_n),
   .sel_b_n      (sel_b_n),
   .sel_c        (sel_c),
   .oe_n         (oe_n),
   .rvalid       (rvalid),
   .active       (active),
   .rd_pend      (rd_pend),
   .cur_addr     (cur_addr)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
   localparam int AW = 6;
   localparam int DW = 32;
   localparam int NW = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, adv_n = 1'b1;
   logic sel_a_n = 1'b0, sel_b_n = 1'b0, sel_c = 1'b1, oe_n = 1'b0;
   logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
   logic [3:0] lane_wr_n = 4'hF;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic rvalid;

   int total = 0;
   int bad = 0;
   bit done = 0;

   burst_sram #(.ADDR_W(AW), .DATA_W(DW), .BURST_W(2)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
      .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c), .oe_n(oe_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
      .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
   );

   always #4 clk = ~clk;

   // reference state derived from the requirements
   logic [DW-1:0] mm [NW];
   bit            m_act = 0;
   logic [AW-1:0] m_cur = '0;
   bit            p_rd = 0;
   logic [AW-1:0] p_addr = '0;

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(string tag);
      bit exp_v;
      logic [DW-1:0] exp_d;
      bit sel, cpu_ok, start, acc;
      logic [AW-1:0] eff;
      logic [3:0] mk;
      exp_v = p_rd && !oe_n && rst_n;
      exp_d = mm[p_addr];
      if (!rst_n) begin
         m_act = 0; p_rd = 0;
      end else begin
         sel    = !sel_a_n && !sel_b_n && sel_c;
         cpu_ok = !strobe_cpu_n && !sel_a_n;
         start  = cpu_ok || !strobe_ctl_n;
         mk     = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_wr_n : 4'h0);
         acc    = 0;
         eff    = m_cur;
         if (start) begin
            if (sel) begin
               acc = 1; m_act = 1; eff = addr;
               if (cpu_ok) mk = 4'h0;
            end else m_act = 0;
         end else if (m_act) begin
            acc = 1;
            if (!adv_n) eff = {m_cur[AW-1:2], m_cur[1:0] + 2'd1};
         end
         if (acc) begin
            m_cur = eff;
            for (int i = 0; i < 4; i++)
               if (mk[i]) mm[eff][8*i +: 8] = wdata[8*i +: 8];
         end
         p_rd = acc && (mk == 4'h0);
         p_addr = eff;
      end
      @(posedge clk);
      @(negedge clk);
      check({tag, " rvalid"}, {31'd0, rvalid}, {31'd0, exp_v});
      if (exp_v) check({tag, " rdata"}, rdata, exp_d);
   endtask

   task automatic idle(string tag);
      tick(tag);
   endtask

   task automatic rd(int a, string tag);
      addr = AW'(a); strobe_ctl_n = 0;
      tick(tag);
      strobe_ctl_n = 1;
   endtask

   task automatic wr(int a, logic [DW-1:0] d, string tag);
      addr = AW'(a); strobe_ctl_n = 0; wr_all_n = 0; wdata = d;
      tick(tag);
      strobe_ctl_n = 1; wr_all_n = 1;
   endtask

   task automatic bwr(int a, logic [3:0] m, logic [DW-1:0] d, string tag);
      addr = AW'(a); strobe_ctl_n = 0; wr_byte_n = 0; lane_wr_n = ~m; wdata = d;
      tick(tag);
      strobe_ctl_n = 1; wr_byte_n = 1; lane_wr_n = 4'hF;
   endtask

   task automatic adv(string tag);
      adv_n = 0;
      tick(tag);
      adv_n = 1;
   endtask

   task automatic desel(string tag);
      sel_a_n = 1; strobe_ctl_n = 0;
      tick(tag);
      sel_a_n = 0; strobe_ctl_n = 1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NW; i++) mm[i] = '0;
      @(negedge clk);
      // R11: reset holds output off; no burst afterwards without strobe
      repeat (3) tick("R11");
      rst_n = 1;
      adv("R11"); adv("R11"); idle("R11");

      // R1: fill and read back every word
      for (int a = 0; a < NW; a++) wr(a, (a * 32'h01030507) ^ 32'hC3A50000, "R1");
      desel("R1");
      for (int a = 0; a < NW; a++) rd(a, "R1");
      desel("R1"); idle("R1");

      // R9: every lane mask, then read back
      for (int m = 0; m < 16; m++) bwr(16 + m, 4'(m), 32'h5A6B7C8D ^ m, "R9");
      desel("R9");
      for (int m = 0; m < 16; m++) rd(16 + m, "R9");
      wr(40, 32'h11223344, "R9"); wr_all_n = 0; wdata = 32'hAABBCCDD; adv("R9"); wr_all_n = 1;
      rd(40, "R9"); adv("R9"); adv("R9");
      desel("R9");

      // R2: single read then deselect
      rd(5, "R2"); desel("R2"); idle("R2"); idle("R2");

      // R3: every base, five beats with wrap
      for (int b = 0; b < NW; b++) begin
         rd(b, "R3");
         for (int k = 0; k < 4; k++) adv("R3");
      end
      desel("R3");

      // R4: pause with advance high
      rd(9, "R4"); adv("R4"); idle("R4"); idle("R4"); adv("R4"); adv("R4"); desel("R4");

      // R5: reload partway through a burst
      rd(22, "R5"); adv("R5"); rd(42, "R5");
      for (int k = 0; k < 4; k++) adv("R5");
      strobe_cpu_n = 0; addr = 6'd3; tick("R5"); strobe_cpu_n = 1; adv("R5");
      desel("R5");

      // R6: each unselected enable combination ends a running burst
      for (int c = 0; c < 8; c++) begin
         if (c == 3'b001) continue;
         rd(12, "R6"); adv("R6");
         {sel_a_n, sel_b_n, sel_c} = 3'(c);
         strobe_ctl_n = 0; tick("R6"); strobe_ctl_n = 1;
         {sel_a_n, sel_b_n, sel_c} = 3'b001;
         idle("R6"); adv("R6"); adv("R6");
      end
      rd(13, "R6"); sel_b_n = 1; strobe_cpu_n = 0; tick("R6");
      strobe_cpu_n = 1; sel_b_n = 0; idle("R6"); adv("R6");

      // R7: ignored processor strobe while primary enable is off
      rd(33, "R7"); adv("R7");
      sel_a_n = 1; strobe_cpu_n = 0; adv_n = 0; addr = 6'd60; tick("R7");
      sel_a_n = 0; strobe_cpu_n = 1; adv_n = 1;
      adv("R7"); desel("R7");
      sel_a_n = 1; strobe_cpu_n = 0; addr = 6'd61; tick("R7");
      sel_a_n = 0; strobe_cpu_n = 1; adv("R7"); idle("R7");

      // R8: processor strobe always reads, and wins over controller strobe
      strobe_cpu_n = 0; wr_all_n = 0; wdata = 32'h0; addr = 6'd50; tick("R8");
      strobe_ctl_n = 0; addr = 6'd51; tick("R8");
      strobe_cpu_n = 1; strobe_ctl_n = 1; wr_all_n = 1;
      rd(50, "R8"); rd(51, "R8"); desel("R8"); idle("R8");

      // R10: output enable gates beats at the data edge
      rd(7, "R10"); oe_n = 1; adv("R10"); adv("R10"); oe_n = 0; adv("R10");
      oe_n = 1; adv("R10"); oe_n = 0; desel("R10"); idle("R10");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule